// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block arbitrates eight interrupt request lines against an in-service register. Priority forms a ring whose lowest position is held in a bottom pointer, and the pointer moves under host command. A request line is latched on its rising edge. An unmasked latched request raises the interrupt output when it outranks everything already in service. An acknowledge strobe then moves the winning level into service.

A host writes 8-bit command words to end service and to steer priority. The command can end service for a level it names or for the top in-service level, and it can rotate the ring in either case. It can also place the bottom pointer directly, or enable a mode in which each acknowledge ends service on its own and rotates the ring. A plain input selects special nested behaviour for a cascade master. In that mode a level that is already in service may interrupt again.

No data stream crosses the block's edge. The command write and the acknowledge are single-cycle strobes that are always accepted, so there is no back-pressure. All state changes on the rising clock edge after a strobe. The interrupt output and the winning level are combinational from the registered state, the mask and the nested-mode input.

Top module: `rot_prio_resolver`

## Requirements
- R1: After reset the in-service register is zero, no request is latched, the interrupt output is low, automatic-end mode is off, and the bottom pointer is 7, so level 0 has top priority.
- R2: A rising edge on a request line latches that level as pending. A set mask bit keeps the latched level out of arbitration, but the level stays pending and competes again once it is unmasked.
- R3: The rank of level L is (L - bottom - 1) mod 8, and rank 0 is the top priority. The winning-level output gives the top-ranked pending unmasked level, or 0 when there is none. The interrupt output is high when such a level exists and, with nested mode off, its rank is strictly above the rank of every in-service level.
- R4: An acknowledge while the interrupt output is high sets the winner's in-service bit and clears its pending latch. An acknowledge while the output is low changes nothing.
- R5: Command bits 7:5 = 001 (for example 0x20) clear the top-ranked in-service bit and leave the bottom pointer unchanged.
- R6: Command bits 7:5 = 011 clear the in-service bit named by bits 2:0.
- R7: Command bits 7:5 = 101 clear the top-ranked in-service bit and make that level the bottom. With nothing in service, this command has no effect.
- R8: Command bits 7:5 = 110 load bits 2:0 into the bottom pointer and leave the in-service register unchanged. For example, bottom 5 gives level 6 the top priority.
- R9: Command bits 7:5 = 111 clear the in-service bit named by bits 2:0 and make that level the bottom.
- R10: Command bits 7:5 = 100 turn on automatic-end rotation, and 000 turn it off. While it is on, an effective acknowledge clears the winner's pending latch, sets no in-service bit, and makes the winner the bottom. Bits 7:5 = 010 do nothing, and bits 4:3 are ignored.
- R11: With the nested-mode input high, a pending level whose rank equals the top in-service rank also raises the interrupt output. This covers a level that is already in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 8 | Request lines; a rising edge latches the level |
| irq_mask | input | 8 | A set bit excludes that level from arbitration |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 8 | Command word: bit 7 rotate, bit 6 level-select, bit 5 end-of-service, bits 2:0 level |
| ack | input | 1 | Acknowledge strobe |
| nest_sp | input | 1 | Special nested mode for a cascade master |
| int_out | output | 1 | Interrupt request to the host |
| win_level | output | 3 | Top-ranked pending unmasked level |
| isr | output | 8 | In-service register |

## Verification
The bench uses the default ring to show that a level masked while latched still wins once it is unmasked. A design that cleared the latch on masking would lose that request. It sends a rotate end-of-service with nothing in service, which must leave the bottom pointer where it was, and it uses bottom 5 to check that level 6 becomes the winner; a ring that is off by one would pick level 7 or level 5. It also acknowledges in automatic-end mode, where a design that still set the in-service bit would block every lower level. In special nested mode it re-requests a level that is already in service: a design that kept the strict comparison would hold the interrupt output low, and one that dropped the comparison would let lower levels through.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
  typedef enum logic [2:0] {
    OP_AEOI_OFF = 3'b000,
    OP_NS_EOI   = 3'b001,
    OP_NOP      = 3'b010,
    OP_SP_EOI   = 3'b011,
    OP_AEOI_ON  = 3'b100,
    OP_ROT_NS   = 3'b101,
    OP_SET_BOT  = 3'b110,
    OP_ROT_SP   = 3'b111
  } rpr_op_e;
endpackage

// File: rtl/rpr_ring_pick.sv
module rpr_ring_pick #(
  parameter int LVL_W = 3,
  localparam int NLVL = 1 << LVL_W
) (
  input  logic [NLVL-1:0]  vec,
  input  logic [LVL_W-1:0] bottom,
  output logic             hit,
  output logic [LVL_W-1:0] lvl,
  output logic [LVL_W-1:0] rank
);
  // Scan from the lowest rank upward; the last match written is the top-ranked one.
  always_comb begin
    hit  = 1'b0;
    lvl  = '0;
    rank = '0;
    for (int r = NLVL - 1; r >= 0; r--) begin
      if (vec[bottom + LVL_W'(1) + LVL_W'(r)]) begin
        hit  = 1'b1;
        rank = LVL_W'(r);
        lvl  = bottom + LVL_W'(1) + LVL_W'(r);
      end
    end
  end
endmodule

// File: rtl/rpr_cmd_decode.sv
module rpr_cmd_decode #(
  parameter int LVL_W = 3,
  localparam int NLVL = 1 << LVL_W
) (
  input  logic             we,
  input  logic [7:0]       data,
  input  logic             top_hit,
  input  logic [LVL_W-1:0] top_lvl,
  output logic [NLVL-1:0]  isr_clr,
  output logic             bot_ld,
  output logic [LVL_W-1:0] bot_val,
  output logic             aeoi_on,
  output logic             aeoi_off
);
  import rpr_pkg::*;
  rpr_op_e          op;
  logic [LVL_W-1:0] named;

  assign op    = rpr_op_e'(data[7:5]);
  assign named = data[LVL_W-1:0];

  always_comb begin
    isr_clr  = '0;
    bot_ld   = 1'b0;
    bot_val  = named;
    aeoi_on  = 1'b0;
    aeoi_off = 1'b0;
    if (we) begin
      unique case (op)
        OP_NS_EOI:   if (top_hit) isr_clr[top_lvl] = 1'b1;
        OP_SP_EOI:   isr_clr[named] = 1'b1;
        OP_ROT_NS: begin
          if (top_hit) begin
            isr_clr[top_lvl] = 1'b1;
            bot_ld           = 1'b1;
            bot_val          = top_lvl;
          end
        end
        OP_ROT_SP: begin
          isr_clr[named] = 1'b1;
          bot_ld         = 1'b1;
        end
        OP_SET_BOT:  bot_ld   = 1'b1;
        OP_AEOI_ON:  aeoi_on  = 1'b1;
        OP_AEOI_OFF: aeoi_off = 1'b1;
        default: ;
      endcase
    end
  end

  // R6 / R9: a command that names a level clears exactly that in-service bit
  always_comb begin
    if (we && data[6] && data[5]) assert (isr_clr == (NLVL'(1) << named));
  end
endmodule

// File: rtl/rot_prio_resolver.sv
module rot_prio_resolver #(
  parameter int LVL_W = 3,
  localparam int NLVL = 1 << LVL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLVL-1:0]  irq_req,
  input  logic [NLVL-1:0]  irq_mask,
  input  logic             cmd_we,
  input  logic [7:0]       cmd_data,
  input  logic             ack,
  input  logic             nest_sp,
  output logic             int_out,
  output logic [LVL_W-1:0] win_level,
  output logic [NLVL-1:0]  isr
);
  logic [NLVL-1:0]  req_d, irr_q, isr_q;
  logic [LVL_W-1:0] bot_q;
  logic             aeoi_q;

  logic             pend_hit, top_hit;
  logic [LVL_W-1:0] pend_lvl, pend_rank, top_lvl, top_rank;
  logic [NLVL-1:0]  isr_clr, ack_bit;
  logic             bot_ld, aeoi_on, aeoi_off, ack_ok;
  logic [LVL_W-1:0] bot_val;

  rpr_ring_pick #(.LVL_W(LVL_W)) u_pend (
    .vec(irr_q & ~irq_mask), .bottom(bot_q),
    .hit(pend_hit), .lvl(pend_lvl), .rank(pend_rank));

  rpr_ring_pick #(.LVL_W(LVL_W)) u_serv (
    .vec(isr_q), .bottom(bot_q),
    .hit(top_hit), .lvl(top_lvl), .rank(top_rank));

  rpr_cmd_decode #(.LVL_W(LVL_W)) u_cmd (
    .we(cmd_we), .data(cmd_data), .top_hit(top_hit), .top_lvl(top_lvl),
    .isr_clr(isr_clr), .bot_ld(bot_ld), .bot_val(bot_val),
    .aeoi_on(aeoi_on), .aeoi_off(aeoi_off));

  always_comb begin
    if (!pend_hit)    int_out = 1'b0;
    else if (!top_hit) int_out = 1'b1;
    else if (nest_sp) int_out = (pend_rank <= top_rank);
    else              int_out = (pend_rank <  top_rank);
  end

  assign win_level = pend_lvl;
  assign isr       = isr_q;
  assign ack_ok    = ack && int_out;
  assign ack_bit   = ack_ok ? (NLVL'(1) << pend_lvl) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_d  <= '0;
      irr_q  <= '0;
      isr_q  <= '0;
      bot_q  <= '1;
      aeoi_q <= 1'b0;
    end else begin
      req_d <= irq_req;
      irr_q <= (irr_q & ~ack_bit) | (irq_req & ~req_d);
      isr_q <= (isr_q | (aeoi_q ? '0 : ack_bit)) & ~isr_clr;
      if (bot_ld)                bot_q <= bot_val;
      else if (ack_ok && aeoi_q) bot_q <= pend_lvl;
      if (aeoi_on)       aeoi_q <= 1'b1;
      else if (aeoi_off) aeoi_q <= 1'b0;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (isr_q == '0) && (irr_q == '0) && (bot_q == '1));

  p_winner_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> irr_q[win_level] && !irq_mask[win_level]);

  p_nested_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (int_out && !nest_sp) |-> !isr_q[win_level]);

  p_ack_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_out && !aeoi_q && !cmd_we) |=> isr_q[$past(win_level)]);

  p_ns_eoi_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_data[7:5] == 3'b001 && isr_q != '0 && !ack)
      |=> $countones(isr_q) == $countones($past(isr_q)) - 1);

  p_set_bot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_data[7:5] == 3'b110 && !ack)
      |=> (bot_q == $past(cmd_data[LVL_W-1:0])) && $stable(isr_q));

  p_aeoi_noset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && aeoi_q && !cmd_we) |=> $stable(isr_q));
endmodule

// File: tb/rot_prio_resolver_tb.sv
module rot_prio_resolver_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_req = '0, irq_mask = '0, cmd_data = '0;
  logic       cmd_we = 1'b0, ack = 1'b0, nest_sp = 1'b0;
  logic       int_out;
  logic [2:0] win_level;
  logic [7:0] isr;

  int total = 0, bad = 0;

  // Model state
  logic [7:0] m_prev, m_irr, m_isr;
  logic [2:0] m_bot;
  logic       m_aeoi;

  always #10 clk = ~clk;

  rot_prio_resolver u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_mask(irq_mask),
    .cmd_we(cmd_we), .cmd_data(cmd_data), .ack(ack), .nest_sp(nest_sp),
    .int_out(int_out), .win_level(win_level), .isr(isr));

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic void best(input logic [7:0] v, input logic [2:0] b,
                               output logic hit, output logic [2:0] lvl, output logic [2:0] rk);
    hit = 1'b0; lvl = '0; rk = '0;
    for (int l = 0; l < 8; l++) begin
      logic [2:0] r;
      r = 3'(l) - b - 3'd1;
      if (v[l] && (!hit || r < rk)) begin
        hit = 1'b1; lvl = 3'(l); rk = r;
      end
    end
  endfunction

  function automatic void expect_out(input logic [7:0] msk, input logic sf,
                                     output logic e_int, output logic [2:0] e_win);
    logic ph, th;
    logic [2:0] pl, pr, tl, tr;
    best(m_irr & ~msk, m_bot, ph, pl, pr);
    best(m_isr, m_bot, th, tl, tr);
    e_win = pl;
    if (!ph) e_int = 1'b0;
    else if (!th) e_int = 1'b1;
    else e_int = sf ? (pr <= tr) : (pr < tr);
  endfunction

  task automatic model_reset();
    m_prev = '0; m_irr = '0; m_isr = '0; m_bot = 3'd7; m_aeoi = 1'b0;
  endtask

  // Drive one cycle at the falling edge, update the model, check at the next falling edge.
  task automatic cyc(input string tag, input logic [7:0] rq, input logic [7:0] msk,
                     input logic we, input logic [7:0] d, input logic ak, input logic sf);
    logic e_int, th, dummy_h;
    logic [2:0] e_win, tl, tr, dl, dr;
    logic [7:0] clr, setb, n_irr, n_isr;
    logic [2:0] n_bot;
    logic       n_aeoi;
    irq_req = rq; irq_mask = msk; cmd_we = we; cmd_data = d; ack = ak; nest_sp = sf;
    expect_out(msk, sf, e_int, e_win);
    best(m_isr, m_bot, th, tl, tr);
    clr = '0; n_bot = m_bot; n_aeoi = m_aeoi;
    setb = (ak && e_int) ? (8'd1 << e_win) : '0;
    if (ak && e_int && m_aeoi) n_bot = e_win;
    if (we) begin
      case (d[7:5])
        3'b001: if (th) clr = 8'd1 << tl;
        3'b011: clr = 8'd1 << d[2:0];
        3'b101: if (th) begin clr = 8'd1 << tl; n_bot = tl; end
        3'b111: begin clr = 8'd1 << d[2:0]; n_bot = d[2:0]; end
        3'b110: n_bot = d[2:0];
        3'b100: n_aeoi = 1'b1;
        3'b000: n_aeoi = 1'b0;
        default: ;
      endcase
    end
    n_irr = (m_irr & ~setb) | (rq & ~m_prev);
    n_isr = (m_isr | (m_aeoi ? 8'd0 : setb)) & ~clr;
    @(posedge clk);
    m_prev = rq; m_irr = n_irr; m_isr = n_isr; m_bot = n_bot; m_aeoi = n_aeoi;
    @(negedge clk);
    expect_out(msk, sf, e_int, e_win);
    best(m_irr & ~msk, m_bot, dummy_h, dl, dr);
    check(tag, "int_out", int'(int_out), int'(e_int));
    check(tag, "win_level", int'(win_level), int'(e_win));
    check(tag, "isr", int'(isr), int'(m_isr));
    cmd_we = 1'b0; ack = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "isr", int'(isr), 0);
    check("R1", "int_out", int'(int_out), 0);
    cyc("R1", 8'h81, 8'h00, 0, 8'h00, 0, 0);
    check("R1", "level0 top", int'(win_level), 0);
    cyc("R3", 8'h00, 8'h00, 0, 8'h00, 0, 0);
    cyc("R4", 8'h00, 8'h00, 0, 8'h00, 1, 0);
    cyc("R4", 8'h00, 8'h00, 0, 8'h00, 1, 0);
    cyc("R5", 8'h00, 8'h00, 1, 8'h20, 0, 0);
    cyc("R5", 8'h00, 8'h00, 1, 8'h20, 0, 0);
    // R3 / R2 fixed order and mask
    cyc("R3", 8'h28, 8'h00, 0, 8'h00, 0, 0);
    check("R3", "winner", int'(win_level), 3);
    cyc("R2", 8'h28, 8'h08, 0, 8'h00, 0, 0);
    check("R2", "masked winner", int'(win_level), 5);
    cyc("R2", 8'h28, 8'h00, 0, 8'h00, 0, 0);
    check("R2", "unmasked still pending", int'(win_level), 3);
    // R4 acknowledge and ignored acknowledge
    cyc("R4", 8'h28, 8'h00, 0, 8'h00, 1, 0);
    check("R4", "isr", int'(isr), 8'h08);
    cyc("R4", 8'h28, 8'h00, 0, 8'h00, 1, 0);
    check("R4", "ignored ack", int'(isr), 8'h08);
    cyc("R3", 8'h2A, 8'h00, 0, 8'h00, 0, 0);
    cyc("R4", 8'h2A, 8'h00, 0, 8'h00, 1, 0);
    cyc("R5", 8'h2A, 8'h00, 1, 8'h20, 0, 0);
    check("R5", "isr after ns eoi", int'(isr), 8'h08);
    cyc("R6", 8'h2A, 8'h00, 1, 8'h63, 0, 0);
    check("R6", "isr after sp eoi", int'(isr), 0);
    cyc("R4", 8'h2A, 8'h00, 0, 8'h00, 1, 0);
    cyc("R7", 8'h2A, 8'h00, 1, 8'hA0, 0, 0);
    cyc("R7", 8'h00, 8'h00, 1, 8'hA0, 0, 0);
    cyc("R7", 8'h50, 8'h00, 0, 8'h00, 0, 0);
    check("R7", "rotated winner", int'(win_level), 6);
    // R8 set bottom
    cyc("R8", 8'h50, 8'h00, 1, 8'hC2, 0, 0);
    check("R8", "bottom 2 winner", int'(win_level), 4);
    cyc("R8", 8'h00, 8'h00, 1, 8'hC5, 0, 0);
    cyc("R8", 8'h41, 8'h00, 0, 8'h00, 0, 0);
    check("R8", "bottom 5 gives 6", int'(win_level), 6);
    // R9 rotate on named level
    cyc("R9", 8'h41, 8'h00, 0, 8'h00, 1, 0);
    cyc("R9", 8'h45, 8'h00, 1, 8'hE6, 0, 0);
    cyc("R9", 8'h45, 8'h00, 1, 8'h58, 0, 0);
    // R10 automatic-end rotation
    cyc("R10", 8'h45, 8'h00, 1, 8'h80, 0, 0);
    cyc("R10", 8'h45, 8'h00, 0, 8'h00, 1, 0);
    check("R10", "no isr bit", int'(isr), 0);
    cyc("R10", 8'h00, 8'h00, 0, 8'h00, 1, 0);
    cyc("R10", 8'h1C, 8'h00, 0, 8'h00, 1, 0);
    cyc("R10", 8'h1C, 8'h00, 1, 8'h00, 0, 0);
    cyc("R10", 8'h1C, 8'h00, 0, 8'h00, 1, 0);
    // R11 special nested mode
    cyc("R11", 8'h00, 8'h00, 0, 8'h00, 0, 1);
    cyc("R11", 8'h1C, 8'h00, 0, 8'h00, 1, 1);
    cyc("R11", 8'h00, 8'h00, 0, 8'h00, 0, 1);
    cyc("R11", 8'h1C, 8'h00, 0, 8'h00, 0, 1);
    cyc("R11", 8'h1C, 8'h00, 0, 8'h00, 0, 0);
    // Random phase
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] rq, msk, d;
      logic we, ak, sf;
      rq  = 8'($urandom);
      msk = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
      we  = (($urandom % 5) == 0);
      d   = 8'($urandom);
      ak  = (($urandom % 3) == 0);
      sf  = (($urandom % 8) == 0);
      cyc("R3", rq, msk, we, d, ak, sf);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule